// File: doc/BRIEF.md
# Data Memory Region Router

This block sits between a processor core's data port and the storage behind it. Each byte-wide read or write carries a 16-bit address. The block decodes that address into one of five targets: the register file, standard I/O, extended I/O, internal SRAM or an external SRAM bus. Two address maps are available. The normal map has an extended I/O window. The compatibility map has no extended I/O window and a smaller internal SRAM that starts right after standard I/O.

Internal targets are reached through one select line per region, an offset inside that region, a write enable and a shared write data bus. Read data comes back on one input per region, and an internal access completes in the cycle it is presented.

An access above the internal range goes to the external bus, but only when external access is enabled. Such an access stalls the core for one base cycle plus one cycle per programmed wait state. During the access the block drives active-low read and write strobes while holding the address and write data steady. When external access is disabled, the access ends at once with an error pulse.

Top module: `dmem_router`

## Requirements
- R1: In the normal map (compat_map_i=0), addresses 0..31 assert sel_rf_o, 32..95 assert sel_io_o, 96..255 assert sel_xio_o and 256..4351 assert sel_ram_o. int_addr_o carries the address minus the region base (0, 32, 96 or 256). At most one select is high, and done_o is high in that same cycle.
- R2: In the compatibility map (compat_map_i=1), 0..31 and 32..95 decode as in R1 and 96..4095 assert sel_ram_o with offset address minus 96. sel_xio_o is never asserted.
- R3: An address above the internal top (4351 normal, 4095 compatibility) up to 65535 targets the external bus when ext_en_i=1. In that case ext_addr_o carries the full 16-bit address.
- R4: When ext_wait_i=W is sampled in the accept cycle, an external access is W+1 cycles longer than an internal one. stall_o is high in the accept cycle and the W cycles that follow. In the next cycle stall_o is low and done_o is high. stall_o and done_o are never high together.
- R5: ext_rd_no and ext_wr_no are active low and never both low. They stay high during the accept cycle and during any internal or refused access. One of them is low in each of the W+1 cycles after acceptance, and ext_addr_o holds steady throughout.
- R6: For an external write, ext_wdata_oe_o is high and ext_wdata_o equals the accepted write data for the whole strobe. For an external read, rdata_o equals ext_rdata_i in the completion cycle.
- R7: With ext_en_i=0, an access above the internal top drives no strobe and no select. It completes in one cycle with done_o=1 and err_o=1, and a read returns 0.
- R8: Requests presented while an external access is in progress are ignored. During that time no select or error is raised, and the address, write data, wait count and length of the access in progress are unchanged.
- R9: For an internal read, rdata_o equals the selected region's read data input. For an internal access, int_we_o follows wr_req_i and int_wdata_o equals wdata_i. When both request lines are high the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request |
| wr_req_i | input | 1 | Write request (wins over read) |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 8 | Write data |
| compat_map_i | input | 1 | 1 selects the compatibility map |
| ext_en_i | input | 1 | External bus enable |
| ext_wait_i | input | 2 | External wait states, 0..3 |
| stall_o | output | 1 | Core stall |
| done_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | External access refused |
| rdata_o | output | 8 | Read data to core |
| sel_rf_o | output | 1 | Register file select |
| sel_io_o | output | 1 | Standard I/O select |
| sel_xio_o | output | 1 | Extended I/O select |
| sel_ram_o | output | 1 | Internal SRAM select |
| int_addr_o | output | 16 | Offset inside the selected region |
| int_we_o | output | 1 | Internal write enable |
| int_wdata_o | output | 8 | Internal write data |
| rf_rdata_i | input | 8 | Register file read data |
| io_rdata_i | input | 8 | Standard I/O read data |
| xio_rdata_i | input | 8 | Extended I/O read data |
| ram_rdata_i | input | 8 | Internal SRAM read data |
| ext_addr_o | output | 16 | External address |
| ext_wdata_o | output | 8 | External write data |
| ext_wdata_oe_o | output | 1 | External data output enable |
| ext_rd_no | output | 1 | External read strobe, active low |
| ext_wr_no | output | 1 | External write strobe, active low |
| ext_rdata_i | input | 8 | External read data |

## Verification
The completion cycle of an external access can coincide with a fresh request on the core side. It is the cycle in which the sequencer releases the bus while new address, data and request lines are already present. The bench provokes this by scrambling every request input in each busy cycle, including the completion cycle, while it keeps a new random value on the external read data. In each of those cycles it judges that no select or error appears, that the strobe, address and write data keep the accepted values, and that done_o arrives exactly W+1 cycles after acceptance carrying the read data of that cycle.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WS_W   = 2;

  typedef enum logic [2:0] {
    RG_RF  = 3'd0,
    RG_IO  = 3'd1,
    RG_XIO = 3'd2,
    RG_RAM = 3'd3,
    RG_EXT = 3'd4
  } region_e;

  localparam int unsigned N_INT = 4;
endpackage

// File: rtl/dmem_region_dec.sv
module dmem_region_dec
  import dmem_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned RF_N     = 32,
  parameter int unsigned IO_N     = 64,
  parameter int unsigned XIO_N    = 160,
  parameter int unsigned RAM_N    = 4096,
  parameter int unsigned RAM_N_C  = 4000
) (
  input  logic [AW-1:0] addr_i,
  input  logic          compat_i,
  output region_e       region_o,
  output logic [AW-1:0] offset_o
);
  localparam int unsigned IO_BASE    = RF_N;
  localparam int unsigned XIO_BASE   = RF_N + IO_N;
  localparam int unsigned RAM_BASE   = XIO_BASE + XIO_N;
  localparam int unsigned RAM_BASE_C = XIO_BASE;
  localparam int unsigned TOP        = RAM_BASE + RAM_N;
  localparam int unsigned TOP_C      = RAM_BASE_C + RAM_N_C;

  logic [31:0]   a;
  logic [AW-1:0] base;

  always_comb begin
    a        = 32'(addr_i);
    region_o = RG_EXT;
    base     = '0;
    if (a < IO_BASE) begin
      region_o = RG_RF;
    end else if (a < XIO_BASE) begin
      region_o = RG_IO;
      base     = AW'(IO_BASE);
    end else if (compat_i) begin
      if (a < TOP_C) begin
        region_o = RG_RAM;
        base     = AW'(RAM_BASE_C);
      end
    end else if (a < RAM_BASE) begin
      region_o = RG_XIO;
      base     = AW'(XIO_BASE);
    end else if (a < TOP) begin
      region_o = RG_RAM;
      base     = AW'(RAM_BASE);
    end
    offset_o = addr_i - base;
  end

  always_comb begin
    assert_no_xio_compat_R2: assert (!(compat_i && region_o == RG_XIO));
  end
endmodule

// File: rtl/dmem_ext_seq.sv
module dmem_ext_seq
  import dmem_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned WSW = WS_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [WSW-1:0] ws_i,
  output logic           busy_o,
  output logic           stall_o,
  output logic           last_o,
  output logic [AW-1:0]  ext_addr_o,
  output logic [DW-1:0]  ext_wdata_o,
  output logic           ext_oe_o,
  output logic           ext_rd_no,
  output logic           ext_wr_no
);
  logic           busy_q, wr_q;
  logic [WSW-1:0] cnt_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        wr_q    <= wr_i;
        cnt_q   <= ws_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign stall_o     = busy_q && (cnt_q != '0);
  assign last_o      = busy_q && (cnt_q == '0);
  assign ext_addr_o  = addr_q;
  assign ext_wdata_o = wdata_q;
  assign ext_oe_o    = busy_q && wr_q;
  assign ext_rd_no   = !(busy_q && !wr_q);
  assign ext_wr_no   = !(busy_q && wr_q);

  assert_one_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_no || ext_wr_no);
  assert_addr_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ext_rd_no && ext_wr_no) && !$past(ext_rd_no && ext_wr_no)) |-> $stable(ext_addr_o));
  assert_wdata_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_wr_no && !$past(ext_wr_no)) |-> $stable(ext_wdata_o));
  assert_stall_then_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (stall_o || last_o));
endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_pkg::*;
#(
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned WSW     = WS_W,
  parameter int unsigned RF_N    = 32,
  parameter int unsigned IO_N    = 64,
  parameter int unsigned XIO_N   = 160,
  parameter int unsigned RAM_N   = 4096,
  parameter int unsigned RAM_N_C = 4000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_req_i,
  input  logic           wr_req_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           compat_map_i,
  input  logic           ext_en_i,
  input  logic [WSW-1:0] ext_wait_i,
  output logic           stall_o,
  output logic           done_o,
  output logic           err_o,
  output logic [DW-1:0]  rdata_o,
  output logic           sel_rf_o,
  output logic           sel_io_o,
  output logic           sel_xio_o,
  output logic           sel_ram_o,
  output logic [AW-1:0]  int_addr_o,
  output logic           int_we_o,
  output logic [DW-1:0]  int_wdata_o,
  input  logic [DW-1:0]  rf_rdata_i,
  input  logic [DW-1:0]  io_rdata_i,
  input  logic [DW-1:0]  xio_rdata_i,
  input  logic [DW-1:0]  ram_rdata_i,
  output logic [AW-1:0]  ext_addr_o,
  output logic [DW-1:0]  ext_wdata_o,
  output logic           ext_wdata_oe_o,
  output logic           ext_rd_no,
  output logic           ext_wr_no,
  input  logic [DW-1:0]  ext_rdata_i
);
  region_e       region;
  logic [AW-1:0] offset;
  logic          busy, seq_stall, seq_last;
  logic          req, ext_tgt, int_acc, start;
  logic [N_INT-1:0] sel;
  logic [DW-1:0] reg_rd [N_INT];

  dmem_region_dec #(
    .AW(AW), .RF_N(RF_N), .IO_N(IO_N), .XIO_N(XIO_N),
    .RAM_N(RAM_N), .RAM_N_C(RAM_N_C)
  ) i_dec (
    .addr_i  (addr_i),
    .compat_i(compat_map_i),
    .region_o(region),
    .offset_o(offset)
  );

  assign req     = rd_req_i || wr_req_i;
  assign ext_tgt = (region == RG_EXT);
  assign int_acc = !busy && req && !ext_tgt;
  assign start   = !busy && req && ext_tgt && ext_en_i;
  assign err_o   = !busy && req && ext_tgt && !ext_en_i;

  dmem_ext_seq #(.AW(AW), .DW(DW), .WSW(WSW)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .wr_i       (wr_req_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ws_i       (ext_wait_i),
    .busy_o     (busy),
    .stall_o    (seq_stall),
    .last_o     (seq_last),
    .ext_addr_o (ext_addr_o),
    .ext_wdata_o(ext_wdata_o),
    .ext_oe_o   (ext_wdata_oe_o),
    .ext_rd_no  (ext_rd_no),
    .ext_wr_no  (ext_wr_no)
  );

  for (genvar g = 0; g < N_INT; g++) begin : g_sel
    assign sel[g] = int_acc && (region == region_e'(3'(g)));
  end

  assign reg_rd[0] = rf_rdata_i;
  assign reg_rd[1] = io_rdata_i;
  assign reg_rd[2] = xio_rdata_i;
  assign reg_rd[3] = ram_rdata_i;

  assign sel_rf_o    = sel[0];
  assign sel_io_o    = sel[1];
  assign sel_xio_o   = sel[2];
  assign sel_ram_o   = sel[3];
  assign int_addr_o  = offset;
  assign int_we_o    = int_acc && wr_req_i;
  assign int_wdata_o = wdata_i;

  assign stall_o = start || seq_stall;
  assign done_o  = int_acc || err_o || seq_last;

  always_comb begin
    rdata_o = '0;
    if (seq_last)     rdata_o = ext_rdata_i;
    else if (int_acc) rdata_o = reg_rd[region[1:0]];
  end

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_rf_o, sel_io_o, sel_xio_o, sel_ram_o}));
  assert_no_strobe_internal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rf_o || sel_io_o || sel_xio_o || sel_ram_o) |-> (ext_rd_no && ext_wr_no));
  assert_refuse_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ext_rd_no && ext_wr_no && rdata_o == '0 && done_o));
  assert_stall_done_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stall_o && done_o));
  assert_ignore_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_rd_no && ext_wr_no) |-> !(sel_rf_o || sel_io_o || sel_xio_o || sel_ram_o || err_o));
endmodule

// File: tb/test_dmem_router.sv
module test_dmem_router;
  localparam time PERIOD = 10ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        rd_req_i = 0, wr_req_i = 0, compat_map_i = 0, ext_en_i = 1;
  logic [15:0] addr_i = 0;
  logic [7:0]  wdata_i = 0, ext_rdata_i = 0;
  logic [1:0]  ext_wait_i = 0;
  logic        stall_o, done_o, err_o, sel_rf_o, sel_io_o, sel_xio_o, sel_ram_o;
  logic        int_we_o, ext_wdata_oe_o, ext_rd_no, ext_wr_no;
  logic [7:0]  rdata_o, int_wdata_o, ext_wdata_o;
  logic [15:0] int_addr_o, ext_addr_o;
  localparam logic [7:0] RF_D = 8'hA1, IO_D = 8'hB2, XIO_D = 8'hC3, RAM_D = 8'hD4;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  dmem_router i_dmem_router (
    .clk_i, .rst_ni, .rd_req_i, .wr_req_i, .addr_i, .wdata_i, .compat_map_i,
    .ext_en_i, .ext_wait_i, .stall_o, .done_o, .err_o, .rdata_o,
    .sel_rf_o, .sel_io_o, .sel_xio_o, .sel_ram_o, .int_addr_o, .int_we_o,
    .int_wdata_o, .rf_rdata_i(RF_D), .io_rdata_i(IO_D), .xio_rdata_i(XIO_D),
    .ram_rdata_i(RAM_D), .ext_addr_o, .ext_wdata_o, .ext_wdata_oe_o,
    .ext_rd_no, .ext_wr_no, .ext_rdata_i
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic int exp_reg(input logic [15:0] a, input bit cm);
    if (a < 32) return 0;
    if (a < 96) return 1;
    if (cm) return (a < 4096) ? 3 : 4;
    if (a < 256) return 2;
    return (a < 4352) ? 3 : 4;
  endfunction

  function automatic logic [15:0] exp_off(input logic [15:0] a, input bit cm);
    case (exp_reg(a, cm))
      0: return a;
      1: return a - 16'd32;
      2: return a - 16'd96;
      3: return cm ? a - 16'd96 : a - 16'd256;
      default: return a;
    endcase
  endfunction

  function automatic logic [7:0] reg_data(input int r);
    case (r)
      0: return RF_D;
      1: return IO_D;
      2: return XIO_D;
      default: return RAM_D;
    endcase
  endfunction

  function automatic logic [3:0] sels();
    return {sel_ram_o, sel_xio_o, sel_io_o, sel_rf_o};
  endfunction

  task automatic access(input bit wr, input logic [15:0] a, input bit cm,
                        input bit en, input logic [1:0] ws);
    logic [7:0] wd;
    logic [7:0] xd;
    int rg;
    wd = 8'($urandom);
    rg = exp_reg(a, cm);
    @(posedge clk_i); #1;
    wr_req_i = wr; rd_req_i = wr ? 1'($urandom) : 1'b1;
    addr_i = a; wdata_i = wd; compat_map_i = cm; ext_en_i = en; ext_wait_i = ws;
    ext_rdata_i = 8'($urandom);
    @(negedge clk_i);
    if (rg < 4) begin
      chk(cm ? "R2 select" : "R1 select", 32'(sels()), 32'(4'b1 << rg));
      chk(cm ? "R2 offset" : "R1 offset", 32'(int_addr_o), 32'(exp_off(a, cm)));
      chk("R1 done", 32'({done_o, stall_o, err_o}), 32'b100);
      chk("R5 strobes idle internal", 32'({ext_rd_no, ext_wr_no}), 32'b11);
      chk("R9 we", 32'(int_we_o), 32'(wr));
      if (wr) chk("R9 wdata", 32'(int_wdata_o), 32'(wd));
      else    chk("R9 rdata", 32'(rdata_o), 32'(reg_data(rg)));
    end else if (!en) begin
      chk("R7 done/stall/err", 32'({done_o, stall_o, err_o}), 32'b101);
      chk("R7 no strobe/sel", 32'({ext_rd_no, ext_wr_no, sels()}), 32'b110000);
      if (!wr) chk("R7 rdata zero", 32'(rdata_o), 32'h0);
    end else begin
      chk("R4 accept stall", 32'({stall_o, done_o}), 32'b10);
      chk("R5 no strobe at accept", 32'({ext_rd_no, ext_wr_no}), 32'b11);
      for (int k = 1; k <= int'(ws) + 1; k++) begin
        @(posedge clk_i); #1;
        addr_i = 16'($urandom); wdata_i = 8'($urandom);
        rd_req_i = 1'($urandom); wr_req_i = 1'($urandom);
        ext_wait_i = 2'($urandom); compat_map_i = 1'($urandom);
        ext_en_i = 1'($urandom);
        xd = 8'($urandom); ext_rdata_i = xd;
        @(negedge clk_i);
        chk("R4 stall", 32'(stall_o), 32'(k <= int'(ws)));
        chk("R4 done", 32'(done_o), 32'(k == int'(ws) + 1));
        chk("R5 strobe", 32'({ext_rd_no, ext_wr_no}), wr ? 32'b10 : 32'b01);
        chk("R3 ext addr", 32'(ext_addr_o), 32'(a));
        chk("R8 ignored", 32'({sels(), err_o}), 32'h0);
        if (wr) chk("R6 wdata", 32'({ext_wdata_oe_o, ext_wdata_o}), 32'({1'b1, wd}));
        else begin
          chk("R6 oe low on read", 32'(ext_wdata_oe_o), 32'h0);
          if (k == int'(ws) + 1) chk("R6 rdata", 32'(rdata_o), 32'(xd));
        end
      end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] dn [10];
    logic [15:0] dc [4];
    void'($urandom(32'd20240611));
    dn = '{16'd0, 16'd31, 16'd32, 16'd95, 16'd96, 16'd255, 16'd256, 16'd4351, 16'd4352, 16'd65535};
    dc = '{16'd95, 16'd96, 16'd4095, 16'd4096};
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 reset idle", 32'({ext_rd_no, ext_wr_no, stall_o, done_o, err_o, sels()}), 32'b11000_0000);
    for (int i = 0; i < 10; i++) begin
      access(1'b0, dn[i], 1'b0, 1'b1, 2'(i));
      access(1'b1, dn[i], 1'b0, 1'b1, 2'(i + 1));
    end
    for (int i = 0; i < 4; i++) begin
      access(1'b0, dc[i], 1'b1, 1'b1, 2'(i));
      access(1'b1, dc[i], 1'b1, 1'b1, 2'(3 - i));
    end
    access(1'b0, 16'd4352, 1'b0, 1'b0, 2'd2);
    access(1'b1, 16'd4096, 1'b1, 1'b0, 2'd1);
    access(1'b0, 16'd4095, 1'b1, 1'b0, 2'd3);
    access(1'b0, 16'd65535, 1'b0, 1'b1, 2'd3);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      case ($urandom % 4)
        0: a = 16'($urandom % 300);
        1: a = 16'(4000 + $urandom % 500);
        2: a = 16'($urandom);
        default: a = 16'($urandom % 4400);
      endcase
      access(1'($urandom), a, 1'($urandom), ($urandom % 5) != 0, 2'($urandom));
    end
    @(posedge clk_i); #1;
    rd_req_i = 0; wr_req_i = 0;
    @(negedge clk_i);
    chk("R5 idle at end", 32'({ext_rd_no, ext_wr_no, stall_o}), 32'b110);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule